// File: doc/BRIEF.md
# Single-Density Read Window and Drive Ready Qualifier

This block sits between a floppy drive and a disc controller that has no data separator of its own. It watches the raw read pulses and keeps a window flag. Each pulse closes the window and starts a bit-interval timer. If the timer runs out before the next pulse, the window opens again. The controller samples the window at the moment a pulse arrives. A closed window means a pulse came early, which is a data one. An open window means the pulse came a full cell after the last one, which is a data zero. With 8 µs cells, ones put pulses 4 µs apart and zeros put them 8 µs apart. The default timer of about 6.5 µs falls between the two.

A separate path decides whether the spinning disc is fit to read. A prescaler makes a slow tick, by default 16 MHz divided by 13. A counter of that tick times the gap between index pulses. When the counter's top bit sets (bit 18 by default, about 213 ms, against a nominal 200 ms revolution), the disc is too slow. Ready is given only after two index pulses in a row, each arriving before that overflow. Any overflow sends the sequence back to its start, so a crawling disc can never look ready. While the motor is off, the whole ready path is held in its start state.

Top module: `flux_window_ready`

## Requirements
- R1: After a synchronous reset, `data_window` is 1, `ready_n` is 1 and `too_slow` is 0.
- R2: A rising edge on `rd_data` closes the window. With two synchroniser stages, `data_window` reads 0 from the third clock edge after the edge is applied.
- R3: If no further read pulse arrives, `data_window` returns to 1 exactly `WIN_CYCLES` clock edges after the edge that closed it. That is 3 + `WIN_CYCLES` edges after the input rose.
- R4: A read pulse clears the window whatever its state. The window read just before a pulse takes effect is 0 for pulses closer than 3 + `WIN_CYCLES` clock edges and 1 for pulses that far apart or more. Window 0 at a pulse means data one; window 1 means data zero.
- R5: While `motor_on` is 0, `ready_n` is 1, `too_slow` is 0 and index pulses have no effect on `ready_n`.
- R6: With the motor on, the first in-time index pulse leaves `ready_n` at 1. The second consecutive in-time pulse drives `ready_n` to 0 from the third clock edge after the index input rose. Further in-time pulses keep it at 0.
- R7: `too_slow` becomes 1 when the index interval counter's top bit (bit `IDX_BITS`-1) sets, that is after 2^(`IDX_BITS`-1) ticks without an index pulse. While `too_slow` is 1, `ready_n` is 1.
- R8: An overflow while ready deasserts ready.
- R9: An index pulse clears the interval counter and so clears `too_slow`.
- R10: After an overflow, two fresh consecutive in-time index pulses are again needed before `ready_n` goes to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_data | input | 1 | Raw read-data pulses from the drive (asynchronous) |
| index_in | input | 1 | Index pulses from the drive (asynchronous) |
| motor_on | input | 1 | 1 while the drive motor is running |
| data_window | output | 1 | Window flag: 0 shortly after a pulse, 1 once the bit-interval timer has run out |
| ready_n | output | 1 | Active-low drive ready |
| too_slow | output | 1 | Index interval counter has overflowed |

## Verification
The read path is driven with pulse spacings well below, just below, exactly at and above the window timeout. This separates the data-one and data-zero classifications and pins the timeout to the exact clock edge. The ready path is driven with a sequence of index intervals: in-time gaps, which tell a one-stage advance apart from full ready; an overlong gap, which must raise `too_slow` and drop ready; and in-time gaps after the overlong one, which must requalify from the start. Index pulses with the motor off show that the off state overrides everything else.

// File: rtl/flux_pkg.sv
// Shared types for the read window and ready qualifier.
// Assumes: nothing beyond IEEE 1800-2017.
package flux_pkg;

    // Stages of the ready qualification sequence
    typedef enum logic [1:0] {
        QS_IDLE  = 2'd0,   // no good revolution seen yet
        QS_ARMED = 2'd1,   // one good index interval seen
        QS_READY = 2'd2    // two consecutive good intervals: ready
    } qual_state_t;

endpackage

// File: rtl/flux_sync_edge.sv
// Synchroniser plus rising-edge detector for an asynchronous pulse input.
// Assumes: the input stays high for at least one clock period and low
// for at least one clock period between pulses.
// rise is high for one cycle, STAGES cycles after the input is sampled.
module flux_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);

    logic [STAGES:0] chain;

    // shift the raw input through the synchroniser and one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-1:0], din};
        end
    end

    // a rising edge is a new 1 behind an old 0
    always_comb begin
        rise = chain[STAGES-1] & ~chain[STAGES];
    end

endmodule

// File: rtl/flux_bit_window.sv
// Bit-interval timer and window latch.
// A read event closes the window and restarts the timer. The window
// opens again after WIN_CYCLES clock edges with no further event.
// Assumes: rd_evt is a single-cycle pulse synchronous to clk.
module flux_bit_window #(
    parameter int WIN_CYCLES = 104
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_evt,
    output logic window
);

    localparam int CW = $clog2(WIN_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

    logic [CW-1:0] cnt;

    // close on a pulse, count while closed, open when the count runs out
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            window <= 1'b1;
            cnt    <= '0;
        end else if (rd_evt) begin
            window <= 1'b0;
            cnt    <= '0;
        end else if (!window) begin
            if (cnt == LAST) begin
                window <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/flux_tick_gen.sv
// Prescaler that makes one enable tick every CLK_PER_TICK clocks while
// enabled. Held at zero while disabled, so timing starts cleanly.
// Assumes: CLK_PER_TICK >= 2.
module flux_tick_gen #(
    parameter int CLK_PER_TICK = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);

    localparam int PW = $clog2(CLK_PER_TICK);
    localparam logic [PW-1:0] LAST = PW'(CLK_PER_TICK - 1);

    logic [PW-1:0] pre;

    // count clocks modulo CLK_PER_TICK while enabled
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pre <= '0;
        end else if (pre == LAST) begin
            pre <= '0;
        end else begin
            pre <= pre + 1'b1;
        end
    end

    // tick on the last count of each period
    always_comb begin
        tick = en && (pre == LAST);
    end

endmodule

// File: rtl/flux_speed_qual.sv
// Index interval timer and ready qualification sequence.
// The counter counts ticks and stops once its top bit sets (too slow).
// An index pulse clears the counter after its state has been sampled.
// Two consecutive index pulses without overflow give ready.
// Any overflow, or motor off, restarts the sequence.
// Assumes: idx_evt and tick are single-cycle pulses synchronous to clk.
module flux_speed_qual
    import flux_pkg::*;
#(
    parameter int IDX_BITS = 19
) (
    input  logic clk,
    input  logic rst_n,
    input  logic motor_on,
    input  logic tick,
    input  logic idx_evt,
    output logic too_slow,
    output logic ready_n
);

    logic [IDX_BITS-1:0] icnt;
    logic                ovf_evt;
    qual_state_t         state;

    assign too_slow = icnt[IDX_BITS-1];

    // overflow happens on the tick that carries into the top bit
    always_comb begin
        ovf_evt = tick && !too_slow && (&icnt[IDX_BITS-2:0]);
    end

    // interval counter: clear on index or motor off, stop once saturated
    always_ff @(posedge clk) begin
        if (!rst_n || !motor_on) begin
            icnt <= '0;
        end else if (idx_evt) begin
            icnt <= '0;
        end else if (tick && !too_slow) begin
            icnt <= icnt + 1'b1;
        end
    end

    // qualification sequence: advance on good index, restart on overflow
    always_ff @(posedge clk) begin
        if (!rst_n || !motor_on) begin
            state <= QS_IDLE;
        end else if (ovf_evt) begin
            state <= QS_IDLE;
        end else if (idx_evt) begin
            if (too_slow) begin
                state <= QS_IDLE;
            end else begin
                case (state)
                    QS_IDLE:  state <= QS_ARMED;
                    QS_ARMED: state <= QS_READY;
                    default:  state <= QS_READY;
                endcase
            end
        end
    end

    // ready only in the final stage
    always_comb begin
        ready_n = (state != QS_READY);
    end

endmodule

// File: rtl/flux_window_ready.sv
// Top level: read-data window and drive-ready qualifier.
// Assumes: rd_data and index_in are asynchronous. motor_on is
// synchronous to clk. The latency figures in the brief hold for
// SYNC_STAGES = 2.
module flux_window_ready #(
    parameter int WIN_CYCLES   = 104,
    parameter int CLK_PER_TICK = 13,
    parameter int IDX_BITS     = 19,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_data,
    input  logic index_in,
    input  logic motor_on,
    output logic data_window,
    output logic ready_n,
    output logic too_slow
);

    logic rd_evt;
    logic idx_evt;
    logic tick;

    flux_sync_edge #(.STAGES(SYNC_STAGES)) u_rd_sync (
        .clk(clk), .rst_n(rst_n), .din(rd_data), .rise(rd_evt)
    );

    flux_sync_edge #(.STAGES(SYNC_STAGES)) u_idx_sync (
        .clk(clk), .rst_n(rst_n), .din(index_in), .rise(idx_evt)
    );

    flux_bit_window #(.WIN_CYCLES(WIN_CYCLES)) u_window (
        .clk(clk), .rst_n(rst_n), .rd_evt(rd_evt), .window(data_window)
    );

    flux_tick_gen #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(motor_on), .tick(tick)
    );

    flux_speed_qual #(.IDX_BITS(IDX_BITS)) u_qual (
        .clk(clk), .rst_n(rst_n), .motor_on(motor_on), .tick(tick),
        .idx_evt(idx_evt), .too_slow(too_slow), .ready_n(ready_n)
    );

endmodule

// File: rtl/flux_window_ready_chk.sv
// Checker for flux_window_ready, bound to every instance of the top.
module flux_window_ready_chk (
    input logic clk,
    input logic rst_n,
    input logic motor_on,
    input logic rd_evt,
    input logic idx_evt,
    input logic data_window,
    input logic ready_n,
    input logic too_slow
);

    // R2: a synchronised read edge closes the window on the next edge
    assert_win_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_evt |=> !data_window);

    // R3: the window never opens on the edge that took a read event
    assert_win_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_window) |-> !$past(rd_evt));

    // R5: motor off forces not-ready and clears the overflow flag
    assert_motor_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !motor_on |=> (ready_n && !too_slow));

    // R6: ready is only ever gained on the edge that took an index event
    assert_ready_on_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_n) |-> $past(idx_evt));

    // R7: never ready while the interval counter has overflowed
    assert_no_ready_slow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        too_slow |-> ready_n);

    // R9: an index event clears the overflow flag
    assert_index_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        idx_evt |=> !too_slow);

endmodule

bind flux_window_ready flux_window_ready_chk u_chk (
    .clk(clk), .rst_n(rst_n), .motor_on(motor_on), .rd_evt(rd_evt),
    .idx_evt(idx_evt), .data_window(data_window), .ready_n(ready_n),
    .too_slow(too_slow)
);

// File: tb/flux_window_ready_tb.sv
// Self-checking bench for flux_window_ready. Small parameters keep the
// run short: a window of 10 cycles, a tick every 2 cycles, and overflow
// after 128 ticks (about 256 cycles).
module flux_window_ready_tb;

    localparam int W   = 10;
    localparam int DIV = 2;
    localparam int IB  = 8;

    // pulse spacing in clock edges, and the window expected just before
    // the next pulse would act (R4: 1 when spacing >= 3 + W)
    localparam int NV = 7;
    localparam int GAPS [NV] = '{4, 5, 8, 12, 13, 14, 20};
    localparam int EXPW [NV] = '{0, 0, 0, 0, 1, 1, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_data = 1'b0;
    logic index_in = 1'b0;
    logic motor_on = 1'b0;
    logic data_window, ready_n, too_slow;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;   // 125 MHz

    flux_window_ready #(
        .WIN_CYCLES(W), .CLK_PER_TICK(DIV), .IDX_BITS(IB), .SYNC_STAGES(2)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .index_in(index_in),
        .motor_on(motor_on), .data_window(data_window), .ready_n(ready_n),
        .too_slow(too_slow)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // raise rd_data for one cycle, then wait until n edges have passed
    task automatic rd_pulse(input int n);
        rd_data = 1'b1;
        @(negedge clk);
        rd_data = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    // raise index_in for one cycle, return once its effect is visible
    task automatic idx_pulse();
        index_in = 1'b1;
        @(negedge clk);
        index_in = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        idle(3);
        chk("R1 window", data_window, 1'b1);
        chk("R1 ready_n", ready_n, 1'b1);
        chk("R1 too_slow", too_slow, 1'b0);
        rst_n = 1'b1;
        idle(2);

        // R4: table of pulse spacings, window just before the next pulse
        for (int i = 0; i < NV; i++) begin
            rd_pulse(GAPS[i]);
            chk($sformatf("R4 gap %0d", GAPS[i]), data_window, EXPW[i][0]);
        end

        // R2 and R3: exact closing and opening edges
        idle(20);
        rd_pulse(2);
        chk("R2 still open before third edge", data_window, 1'b1);
        idle(1);
        chk("R2 closed at third edge", data_window, 1'b0);
        idle(W - 1);
        chk("R3 closed one edge before timeout", data_window, 1'b0);
        idle(1);
        chk("R3 open at timeout", data_window, 1'b1);

        // R5: motor off, index pulses do nothing
        idle(5);
        idx_pulse();
        idle(150);
        idx_pulse();
        chk("R5 ready_n motor off", ready_n, 1'b1);
        idle(300);
        chk("R5 too_slow motor off", too_slow, 1'b0);

        // R6: two in-time index pulses give ready
        motor_on = 1'b1;
        idle(150);
        idx_pulse();
        chk("R6 first index not ready", ready_n, 1'b1);
        idle(150);
        idx_pulse();
        chk("R6 second index ready", ready_n, 1'b0);
        chk("R6 not slow", too_slow, 1'b0);
        idle(150);
        idx_pulse();
        chk("R6 stays ready", ready_n, 1'b0);

        // R7 and R8: overlong gap, overflow drops ready
        idle(300);
        chk("R7 too_slow set", too_slow, 1'b1);
        chk("R8 ready dropped", ready_n, 1'b1);

        // R9: index clears overflow
        idx_pulse();
        chk("R9 too_slow cleared", too_slow, 1'b0);
        chk("R10 late index not ready", ready_n, 1'b1);

        // R10: must requalify from the start
        idle(150);
        idx_pulse();
        chk("R10 one good after overflow", ready_n, 1'b1);
        idle(150);
        idx_pulse();
        chk("R10 two good after overflow", ready_n, 1'b0);

        // R5: motor off while ready
        motor_on = 1'b0;
        idle(1);
        chk("R5 motor off drops ready", ready_n, 1'b1);
        chk("R5 motor off clears slow", too_slow, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule